// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block orders memory requests for one DRAM channel. Requesting cores push read or write requests into a short queue. Each request names a core, a bank, a row and a column. Every cycle the scheduler looks at all pending requests whose bank is free and picks at most one of them. It then issues the DRAM command that request needs next: a precharge, an activate, or a column read or write.

A request whose bank already holds its row in the row buffer is a hit, and hits are always served first. Within hits, and within misses when no hit can go, the request that has waited longest is served first. The core ID is carried through but takes no part in the decision. A core that streams requests to an open row can therefore hold back another core's single request to a different row.

Every bank has a two-state controller, `BK_CLOSED` and `BK_OPEN`. The transition `CLOSED->OPEN` happens on an activate, which also loads the row number. The transition `OPEN->CLOSED` happens on a precharge. A column access leaves the state as it is. After any command to a bank, that bank is blocked for `gap_cycles` further cycles. The queue keeps its entries packed in arrival order, so position 0 always holds the oldest request.

Top module: `rowhit_sched`

## Requirements
- R1: After reset the queue is empty, `cmd_valid` is low, `req_ready` is high and every bank is closed.
- R2: `req_ready` is low while DEPTH requests are pending. A request presented while `req_ready` is low is dropped and never produces a command.
- R3: A request to a closed bank produces an activate with the request's row, then a column command. No precharge is issued for it.
- R4: A request to the row open in its bank produces only the column command: read (`cmd_kind`=3) or write (`cmd_kind`=4), chosen by `req_wr`.
- R5: A request to a bank that has a different row open produces a precharge (`cmd_kind`=1), then an activate (`cmd_kind`=2) of the new row, then the column command.
- R6: An eligible hit is chosen before any eligible miss, even when the miss is older.
- R7: Among eligible requests of equal hit status, the oldest is chosen first.
- R8: The core ID does not affect selection. Column commands carry the request's core ID on `cmd_core`.
- R9: At most one command issues per cycle. After a command to a bank, that bank gets no further command for `gap_cycles` cycles, while other banks may still be served.
- R10: A command appears on the outputs in the cycle after the clock edge that makes it selectable. `cmd_kind` is 0 when no command issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_cycles | input | GAP_W | Number of cycles a bank is blocked after each command |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can accept a request |
| req_core | input | CORE_W | Requesting core ID |
| req_bank | input | log2(NBANK) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wr | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_kind | output | 3 | 0 none, 1 precharge, 2 activate, 3 read, 4 write |
| cmd_bank | output | log2(NBANK) | Bank of the command |
| cmd_row | output | ROW_W | Row of the request being served |
| cmd_col | output | COL_W | Column of the request being served |
| cmd_core | output | CORE_W | Core ID of the request being served |

## Verification
A request accepted at edge k can issue its first command at edge k+1. A bank that received a command at edge e can take its next command no earlier than edge e+`gap_cycles`+1. The bench drives and samples on falling edges. A monitor records each command together with the value of a rising-edge cycle counter, and the checks compare these recorded cycle numbers against the exact offsets above as well as the expected command order. Ordering scenarios set a large gap so that several requests queue up behind a blocked bank before any choice among them is made.

// File: rtl/rowhit_pkg.sv
package rowhit_pkg;
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_PRE  = 3'd1,
        CMD_ACT  = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4
    } cmd_kind_e;
endpackage

// File: rtl/rowhit_queue.sv
// Arrival-ordered request store: entries stay packed at the low end, slot 0 is oldest.
module rowhit_queue #(
    parameter int DEPTH = 4,
    parameter int EW    = 20,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [EW-1:0]             push_ent,
    input  logic                      pop,
    input  logic [IDX_W-1:0]          pop_idx,
    output logic [DEPTH-1:0][EW-1:0]  ent,
    output logic [DEPTH-1:0]          valid,
    output logic [CNT_W-1:0]          count,
    output logic                      full
);
    logic [DEPTH-1:0][EW-1:0] n_ent;
    logic [DEPTH-1:0]         n_valid;
    logic [CNT_W-1:0]         n_count;
    logic [CNT_W-1:0]         base;

    always_comb begin
        n_ent   = ent;
        n_valid = valid;
        if (pop) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= int'(pop_idx)) begin
                    if (i < DEPTH - 1) begin
                        n_ent[i]   = ent[(i + 1) % DEPTH];
                        n_valid[i] = valid[(i + 1) % DEPTH];
                    end else begin
                        n_valid[i] = 1'b0;
                    end
                end
            end
        end
        base = count - CNT_W'(pop);
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == base) begin
                    n_ent[i]   = push_ent;
                    n_valid[i] = 1'b1;
                end
            end
        end
        n_count = base + CNT_W'(push);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent   <= '0;
            valid <= '0;
            count <= '0;
        end else begin
            ent   <= n_ent;
            valid <= n_valid;
            count <= n_count;
        end
    end

    assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rowhit_bank.sv
// One bank: open/closed state machine, open row register and post-command block counter.
module rowhit_bank #(
    parameter int ROW_W = 8,
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_pre,
    input  logic             issue_act,
    input  logic             issue_col,
    input  logic [ROW_W-1:0] act_row,
    input  logic [GAP_W-1:0] gap,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             busy
);
    typedef enum logic {BK_CLOSED, BK_OPEN} bank_state_e;
    bank_state_e state, state_nxt;
    logic [GAP_W-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BK_CLOSED;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            BK_CLOSED: if (issue_act) state_nxt = BK_OPEN;
            BK_OPEN:   if (issue_pre) state_nxt = BK_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_row <= '0;
            hold_cnt <= '0;
        end else begin
            if (issue_act) open_row <= act_row;
            if (issue_pre || issue_act || issue_col) hold_cnt <= gap;
            else if (hold_cnt != '0)                 hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_comb begin
        is_open = (state == BK_OPEN);
        busy    = (hold_cnt != '0);
    end
endmodule

// File: rtl/rowhit_pick.sv
// Two-level choice: lowest-slot eligible hit, else lowest-slot eligible request.
module rowhit_pick #(
    parameter int DEPTH  = 4,
    parameter int NBANK  = 4,
    parameter int ROW_W  = 8,
    localparam int BANK_W = $clog2(NBANK),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             valid,
    input  logic [DEPTH-1:0][BANK_W-1:0] e_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]  e_row,
    input  logic [NBANK-1:0]             bank_open,
    input  logic [NBANK-1:0][ROW_W-1:0]  bank_row,
    input  logic [NBANK-1:0]             bank_busy,
    output logic                         found,
    output logic [IDX_W-1:0]             sel_idx,
    output logic                         sel_hit
);
    logic [DEPTH-1:0] elig, hit;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cls
            assign elig[g] = valid[g] && !bank_busy[e_bank[g]];
            assign hit[g]  = elig[g] && bank_open[e_bank[g]] &&
                             (bank_row[e_bank[g]] == e_row[g]);
        end
    endgenerate

    logic             hit_any, elig_any;
    logic [IDX_W-1:0] hit_idx, elig_idx;

    always_comb begin
        hit_any  = 1'b0;
        elig_any = 1'b0;
        hit_idx  = '0;
        elig_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (elig[i]) begin
                elig_any = 1'b1;
                elig_idx = IDX_W'(i);
            end
        end
        found   = elig_any;
        sel_hit = hit_any;
        sel_idx = hit_any ? hit_idx : elig_idx;
    end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
    parameter int DEPTH  = 4,
    parameter int NBANK  = 4,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int CORE_W = 2,
    parameter int GAP_W  = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAP_W-1:0]  gap_cycles,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_wr,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [CORE_W-1:0] cmd_core
);
    import rowhit_pkg::*;

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int COL_LO  = 1;
    localparam int ROW_LO  = COL_LO + COL_W;
    localparam int BANK_LO = ROW_LO + ROW_W;
    localparam int CORE_LO = BANK_LO + BANK_W;
    localparam int EW      = CORE_LO + CORE_W;

    logic [DEPTH-1:0][EW-1:0]     q_ent;
    logic [DEPTH-1:0]             q_valid;
    logic [CNT_W-1:0]             q_count;
    logic                         q_full;
    logic [DEPTH-1:0][BANK_W-1:0] e_bank;
    logic [DEPTH-1:0][ROW_W-1:0]  e_row;
    logic [NBANK-1:0]             bank_open, bank_busy;
    logic [NBANK-1:0][ROW_W-1:0]  bank_row;
    logic                         found, sel_hit, pop;
    logic [IDX_W-1:0]             sel_idx;
    logic [EW-1:0]                sel_ent;
    cmd_kind_e                    nxt_kind;

    assign req_ready = !q_full;

    rowhit_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid && req_ready),
        .push_ent({req_core, req_bank, req_row, req_col, req_wr}),
        .pop(pop), .pop_idx(sel_idx),
        .ent(q_ent), .valid(q_valid), .count(q_count), .full(q_full)
    );

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_fld
            assign e_bank[g] = q_ent[g][BANK_LO +: BANK_W];
            assign e_row[g]  = q_ent[g][ROW_LO +: ROW_W];
        end
    endgenerate

    rowhit_pick #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W)) u_pick (
        .valid(q_valid), .e_bank(e_bank), .e_row(e_row),
        .bank_open(bank_open), .bank_row(bank_row), .bank_busy(bank_busy),
        .found(found), .sel_idx(sel_idx), .sel_hit(sel_hit)
    );

    assign sel_ent = q_ent[sel_idx];

    always_comb begin
        pop      = 1'b0;
        nxt_kind = CMD_NONE;
        if (found) begin
            if (sel_hit) begin
                nxt_kind = sel_ent[0] ? CMD_WR : CMD_RD;
                pop      = 1'b1;
            end else if (bank_open[sel_ent[BANK_LO +: BANK_W]]) begin
                nxt_kind = CMD_PRE;
            end else begin
                nxt_kind = CMD_ACT;
            end
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic here;
            assign here = (sel_ent[BANK_LO +: BANK_W] == BANK_W'(b));
            rowhit_bank #(.ROW_W(ROW_W), .GAP_W(GAP_W)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .issue_pre(here && nxt_kind == CMD_PRE),
                .issue_act(here && nxt_kind == CMD_ACT),
                .issue_col(here && pop),
                .act_row(sel_ent[ROW_LO +: ROW_W]),
                .gap(gap_cycles),
                .is_open(bank_open[b]), .open_row(bank_row[b]), .busy(bank_busy[b])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_NONE;
            cmd_bank  <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            cmd_core  <= '0;
        end else begin
            cmd_valid <= found;
            cmd_kind  <= nxt_kind;
            cmd_bank  <= sel_ent[BANK_LO +: BANK_W];
            cmd_row   <= sel_ent[ROW_LO +: ROW_W];
            cmd_col   <= sel_ent[COL_LO +: COL_W];
            cmd_core  <= sel_ent[CORE_LO +: CORE_W];
        end
    end
endmodule

// File: rtl/rowhit_sched_chk.sv
module rowhit_sched_chk #(
    parameter int DEPTH = 4,
    parameter int NBANK = 4,
    parameter int ROW_W = 8,
    parameter int GAP_W = 4,
    localparam int BANK_W = $clog2(NBANK),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_ready,
    input logic [CNT_W-1:0]            q_count,
    input logic [GAP_W-1:0]            gap_cycles,
    input logic                        cmd_valid,
    input logic [2:0]                  cmd_kind,
    input logic [BANK_W-1:0]           cmd_bank,
    input logic [ROW_W-1:0]            cmd_row,
    input logic [NBANK-1:0]            bank_open,
    input logic [NBANK-1:0][ROW_W-1:0] bank_row
);
    logic [NBANK-1:0]            prev_open;
    logic [NBANK-1:0][ROW_W-1:0] prev_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_open <= '0;
            prev_row  <= '0;
        end else begin
            prev_open <= bank_open;
            prev_row  <= bank_row;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && q_count == '0));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count <= CNT_W'(DEPTH)) && ((q_count == CNT_W'(DEPTH)) -> !req_ready));

    // R3
    act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd2) |-> !prev_open[cmd_bank]);

    // R5
    pre_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd1) |-> prev_open[cmd_bank]);

    // R4
    col_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_kind == 3'd3 || cmd_kind == 3'd4)) |->
        (prev_open[cmd_bank] && prev_row[cmd_bank] == cmd_row));

    // R9
    bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(cmd_valid) && cmd_bank == $past(cmd_bank)) |->
        ($past(gap_cycles) == '0));

    // R10
    idle_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_kind == 3'd0));
endmodule

bind rowhit_sched rowhit_sched_chk #(
    .DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .GAP_W(GAP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .q_count(q_count),
    .gap_cycles(gap_cycles), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .bank_open(bank_open), .bank_row(bank_row)
);

// File: tb/rowhit_sched_test.sv
`timescale 1ns/1ps
module rowhit_sched_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] gap_cycles = '0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_core = '0;
    logic [1:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic [5:0] req_col = '0;
    logic       req_wr = 1'b0;
    logic       cmd_valid;
    logic [2:0] cmd_kind;
    logic [1:0] cmd_bank;
    logic [7:0] cmd_row;
    logic [5:0] cmd_col;
    logic [1:0] cmd_core;

    always #4 clk = ~clk;

    rowhit_sched uut (
        .clk(clk), .rst_n(rst_n), .gap_cycles(gap_cycles),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wr(req_wr),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_core(cmd_core)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    bit done = 0;
    int log_n = 0;
    int lk[32], lb[32], lr[32], lc[32], lo[32], lt[32];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && cmd_valid && log_n < 32) begin
            lk[log_n] = int'(cmd_kind);
            lb[log_n] = int'(cmd_bank);
            lr[log_n] = int'(cmd_row);
            lc[log_n] = int'(cmd_col);
            lo[log_n] = int'(cmd_core);
            lt[log_n] = cyc;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 1 pre, 2 act, 3 rd, 4 wr; row checked for act and column, col/core for column
    task automatic chk_ent(input string req, input int i, input int kind, input int bank,
                           input int row, input int col, input int core);
        chk({req, " kind"}, lk[i], kind);
        chk({req, " bank"}, lb[i], bank);
        if (kind >= 2) chk({req, " row"}, lr[i], row);
        if (kind >= 3) begin
            chk({req, " col"}, lc[i], col);
            chk({req, " core"}, lo[i], core);
        end
    endtask

    task automatic push_one(input int core, input int bank, input int row,
                            input int col, input int wr);
        @(negedge clk);
        req_core  = 2'(core);
        req_bank  = 2'(bank);
        req_row   = 8'(row);
        req_col   = 6'(col);
        req_wr    = wr[0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 cmd_valid after reset", int'(cmd_valid), 0);
        chk("R1 req_ready after reset", int'(req_ready), 1);
        chk("R10 cmd_kind idle", int'(cmd_kind), 0);
    endtask

    task automatic t_closed_bank;
        gap_cycles = 4'd0;
        log_n = 0;
        push_one(0, 0, 5, 3, 0);
        chk("R10 no command at acceptance cycle", int'(cmd_valid), 0);
        @(negedge clk);
        chk("R10 command one cycle later", int'(cmd_valid), 1);
        chk("R3 first command on closed bank", int'(cmd_kind), 2);
        idle(5);
        chk("R3 command count", log_n, 2);
        chk_ent("R3 activate", 0, 2, 0, 5, 0, 0);
        chk_ent("R3 column read", 1, 3, 0, 5, 3, 0);
    endtask

    task automatic t_hit;
        log_n = 0;
        push_one(1, 0, 5, 7, 1);
        idle(5);
        chk("R4 command count", log_n, 1);
        chk_ent("R4 direct write", 0, 4, 0, 5, 7, 1);
    endtask

    task automatic t_conflict;
        log_n = 0;
        push_one(2, 0, 9, 1, 0);
        idle(6);
        chk("R5 command count", log_n, 3);
        chk_ent("R5 precharge", 0, 1, 0, 0, 0, 0);
        chk_ent("R5 activate", 1, 2, 0, 9, 0, 0);
        chk_ent("R5 read", 2, 3, 0, 9, 1, 2);
        chk("R9 back-to-back with zero gap", lt[2] - lt[1], 1);
    endtask

    task automatic t_hit_first_full;
        gap_cycles = 4'd12;
        log_n = 0;
        push_one(0, 0, 9, 0, 0);   // C: hit, blocks bank 0
        push_one(3, 0, 3, 5, 0);   // A: older miss from core 3
        push_one(0, 0, 9, 1, 0);   // B1
        push_one(0, 0, 9, 2, 1);   // B2
        push_one(0, 0, 9, 3, 0);   // B3
        chk("R2 ready low when full", int'(req_ready), 0);
        @(negedge clk);
        req_core = 2'd1; req_bank = 2'd3; req_row = 8'h77; req_col = 6'd9; req_wr = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        idle(110);
        chk("R6 command count", log_n, 7);
        chk_ent("R4 hit C", 0, 3, 0, 9, 0, 0);
        chk_ent("R6 hit B1 before older miss", 1, 3, 0, 9, 1, 0);
        chk_ent("R8 hit B2 (write)", 2, 4, 0, 9, 2, 0);
        chk_ent("R7 hit B3", 3, 3, 0, 9, 3, 0);
        chk_ent("R8 miss precharge", 4, 1, 0, 0, 0, 0);
        chk_ent("R8 miss activate", 5, 2, 0, 3, 0, 0);
        chk_ent("R8 core 3 read", 6, 3, 0, 3, 5, 3);
        chk("R9 gap between bank 0 commands", lt[2] - lt[1], 13);
        begin
            int bad = 0;
            for (int i = 0; i < log_n; i++) if (lb[i] == 3) bad++;
            chk("R2 dropped request never issued", bad, 0);
        end
    endtask

    task automatic t_oldest;
        gap_cycles = 4'd6;
        log_n = 0;
        push_one(1, 1, 1, 0, 0);   // F
        push_one(1, 1, 4, 1, 0);   // D
        push_one(2, 1, 5, 2, 1);   // E
        idle(70);
        chk("R7 command count", log_n, 8);
        chk_ent("R3 F activate", 0, 2, 1, 1, 0, 0);
        chk_ent("R6 F read", 1, 3, 1, 1, 0, 1);
        chk_ent("R7 D precharge", 2, 1, 1, 0, 0, 0);
        chk_ent("R7 D activate first", 3, 2, 1, 4, 0, 0);
        chk_ent("R7 D read", 4, 3, 1, 4, 1, 1);
        chk_ent("R7 E precharge", 5, 1, 1, 0, 0, 0);
        chk_ent("R7 E activate", 6, 2, 1, 5, 0, 0);
        chk_ent("R7 E write", 7, 4, 1, 5, 2, 2);
    endtask

    task automatic t_gap_banks;
        gap_cycles = 4'd5;
        log_n = 0;
        push_one(0, 2, 1, 3, 0);   // X
        push_one(1, 3, 2, 4, 1);   // Y
        idle(20);
        chk("R9 command count", log_n, 4);
        chk_ent("R3 X activate", 0, 2, 2, 1, 0, 0);
        chk_ent("R3 Y activate", 1, 2, 3, 2, 0, 0);
        chk_ent("R9 X read", 2, 3, 2, 1, 3, 0);
        chk_ent("R9 Y write", 3, 4, 3, 2, 4, 1);
        chk("R9 other bank served while blocked", lt[1] - lt[0], 2);
        chk("R9 X waits gap+1", lt[2] - lt[0], 6);
        chk("R9 Y waits gap+1", lt[3] - lt[1], 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_closed_bank();
        t_hit();
        t_conflict();
        t_hit_first_full();
        t_oldest();
        t_gap_banks();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule